// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block steps the address of a horizontally microcoded controller. Only the 9-bit microprogram address is registered; the microinstruction it selects goes straight back into the sequencer without a pipeline stage. In every cycle the sequencer picks the next address from one of four choices. It can use the incremented address, the top of a four-entry return stack, or a jump target. The fourth choice is a conditional jump that falls through to the incremented address when its test fails.

A jump target is page-relative: the page bit supplies the most significant address bit and the 8-bit constant field supplies the rest. A conditional jump reads one of several condition lines through a select field, and a polarity bit chooses whether it jumps on a one or on a zero. Stack traffic is controlled separately from the address choice: an enable says that a stack operation happens, and a direction bit picks push or pop. This lets the microcode build calls (jump plus push), returns (stack plus pop), and stack jumps that do not move the pointer. A host acknowledge input freezes the sequencer so the host can take over shared resources.

Top module: `useq_sequencer`

## Requirements
- R1: A synchronous reset sets the address output to 0 at the next rising edge and empties the stack.
- R2: With source code 0 the next address is the current address plus one, modulo 512, so 511 steps to 0.
- R3: With source code 2 the next address is {page_i, const_i}, with page_i as bit 8.
- R4: With source code 3 the jump to {page_i, const_i} is taken when cond_i[cond_sel_i] equals cond_pol_i. Otherwise the next address is the current address plus one.
- R5: When stk_en_i=1 and stk_push_i=1 the stack saves the current address plus one, so a later return resumes after the call.
- R6: With source code 1 the next address is the top stack entry. With stk_en_i=0 the stack depth is unchanged, so repeating the stack jump gives the same address.
- R7: Up to four nested pushes come back in last-in, first-out order on pops (stk_en_i=1, stk_push_i=0).
- R8: A push onto a full stack drops the oldest entry and keeps the newest four.
- R9: A pop of the last entry leaves it readable. Further pops of an empty stack return that same address, and the depth does not underflow.
- R10: While hold_i=1 the address output and the stack contents stay unchanged, whatever the other inputs are.
- R11: stk_push_i has no effect while stk_en_i=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_i | input | 1 | Host acknowledge; freezes stepping while high |
| src_i | input | 2 | Next-address source: 0 step, 1 stack, 2 jump, 3 conditional jump |
| page_i | input | 1 | Page bit, MSB of the jump target |
| const_i | input | 8 | Constant field, low bits of the jump target |
| cond_i | input | 8 | Condition lines |
| cond_sel_i | input | 3 | Selects the tested condition line |
| cond_pol_i | input | 1 | Value of the selected line that makes the jump taken |
| stk_en_i | input | 1 | Enables a stack operation this cycle |
| stk_push_i | input | 1 | 1 push, 0 pop (when enabled) |
| upc_o | output | 9 | Registered microprogram address |

## Verification
The assertions assume that the control inputs are settled before each rising edge, and that cond_sel_i always names an existing condition line. They also assume reset is held for at least one edge before checks begin. The bench changes every input only on the falling clock edge, drives the select only through the eight real lines, and starts with a reset. Its reference model covers deep call chains, overflow and empty pops. While hold_i is high it drives jumps and pushes, so that the freeze is visible at the output and in the stack content that is returned later.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [1:0] {
    SRC_SEQ  = 2'd0,
    SRC_STK  = 2'd1,
    SRC_JMP  = 2'd2,
    SRC_CJMP = 2'd3
  } src_e;
endpackage

// File: rtl/useq_cond_sel.sv
module useq_cond_sel #(
  parameter int NCOND = 8,
  localparam int SELW = (NCOND > 1) ? $clog2(NCOND) : 1
) (
  input  logic [NCOND-1:0] cond_i,
  input  logic [SELW-1:0]  sel_i,
  input  logic             pol_i,
  output logic             hit_o
);
  logic [NCOND-1:0] match;

  // One comparator per condition line; the select picks one result.
  for (genvar g = 0; g < NCOND; g++) begin : g_line
    assign match[g] = (sel_i == SELW'(g)) && (cond_i[g] == pol_i);
  end

  assign hit_o = |match;
endmodule

// File: rtl/useq_lifo.sv
module useq_lifo #(
  parameter int DW    = 9,
  parameter int DEPTH = 4,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] top_o
);
  logic [DW-1:0] ent_q [DEPTH];
  logic [DW-1:0] ent_d [DEPTH];
  logic [CNTW-1:0] cnt_q;
  logic [CNTW-1:0] cnt_d;

  // Entry 0 is the top of stack; a push shifts everything down by one and
  // drops the deepest entry, a pop shifts up while more than one remains.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) ent_d[i] = ent_q[i];
    cnt_d = cnt_q;
    if (en_i) begin
      if (push_i) begin
        ent_d[0] = din_i;
        for (int i = 1; i < DEPTH; i++) ent_d[i] = ent_q[i-1];
        if (cnt_q != CNTW'(DEPTH)) cnt_d = cnt_q + CNTW'(1);
      end else begin
        if (cnt_q > CNTW'(1)) begin
          for (int i = 0; i < DEPTH - 1; i++) ent_d[i] = ent_q[i+1];
        end
        if (cnt_q != '0) cnt_d = cnt_q - CNTW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
      cnt_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
      cnt_q <= cnt_d;
    end
  end

  assign top_o = ent_q[0];

  // R8: occupancy never exceeds the depth
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNTW'(DEPTH));

  // R5: a pushed value is visible on top one cycle later
  a_r5_push_lands: assert property (@(posedge clk) disable iff (rst)
    (en_i && push_i) |=> (top_o == $past(din_i)));

  // R9: popping an empty stack changes neither depth nor the returned value
  a_r9_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (en_i && !push_i && cnt_q == '0) |=> (cnt_q == '0 && $stable(top_o)));
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int CW = 8,
  localparam int AW = CW + 1
) (
  input  src_e          src_i,
  input  logic [AW-1:0] upc_i,
  input  logic [AW-1:0] tos_i,
  input  logic          page_i,
  input  logic [CW-1:0] const_i,
  input  logic          hit_i,
  output logic [AW-1:0] inc_o,
  output logic [AW-1:0] nxt_o
);
  logic [AW-1:0] target;

  assign inc_o  = upc_i + AW'(1);
  assign target = {page_i, const_i};

  always_comb begin
    unique case (src_i)
      SRC_SEQ:  nxt_o = inc_o;
      SRC_STK:  nxt_o = tos_i;
      SRC_JMP:  nxt_o = target;
      SRC_CJMP: nxt_o = hit_i ? target : inc_o;
      default:  nxt_o = inc_o;
    endcase
  end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int CW    = 8,
  parameter int DEPTH = 4,
  parameter int NCOND = 8,
  localparam int AW   = CW + 1,
  localparam int SELW = (NCOND > 1) ? $clog2(NCOND) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_i,
  input  logic [1:0]       src_i,
  input  logic             page_i,
  input  logic [CW-1:0]    const_i,
  input  logic [NCOND-1:0] cond_i,
  input  logic [SELW-1:0]  cond_sel_i,
  input  logic             cond_pol_i,
  input  logic             stk_en_i,
  input  logic             stk_push_i,
  output logic [AW-1:0]    upc_o
);
  src_e          src;
  logic          hit;
  logic [AW-1:0] upc_q;
  logic [AW-1:0] inc;
  logic [AW-1:0] nxt;
  logic [AW-1:0] tos;

  assign src = src_e'(src_i);

  useq_cond_sel #(.NCOND(NCOND)) u_cond (
    .cond_i (cond_i),
    .sel_i  (cond_sel_i),
    .pol_i  (cond_pol_i),
    .hit_o  (hit)
  );

  useq_lifo #(.DW(AW), .DEPTH(DEPTH)) u_stack (
    .clk    (clk),
    .rst    (rst),
    .en_i   (stk_en_i && !hold_i),
    .push_i (stk_push_i),
    .din_i  (inc),
    .top_o  (tos)
  );

  useq_next_addr #(.CW(CW)) u_next (
    .src_i   (src),
    .upc_i   (upc_q),
    .tos_i   (tos),
    .page_i  (page_i),
    .const_i (const_i),
    .hit_i   (hit),
    .inc_o   (inc),
    .nxt_o   (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)          upc_q <= '0;
    else if (!hold_i) upc_q <= nxt;
  end

  assign upc_o = upc_q;

  // R10: the host acknowledge freezes the address
  a_r10_hold_pc: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> $stable(upc_o));

  // R2: plain stepping advances by one, modulo the address width
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (!hold_i && src_i == 2'd0) |=> (upc_o == $past(upc_o) + AW'(1)));

  // R3: an unconditional jump lands on the page-relative target
  a_r3_jump: assert property (@(posedge clk) disable iff (rst)
    (!hold_i && src_i == 2'd2) |=> (upc_o == $past({page_i, const_i})));

  // R4: a failed condition falls through to the next address
  a_r4_fallthru: assert property (@(posedge clk) disable iff (rst)
    (!hold_i && src_i == 2'd3 && cond_i[cond_sel_i] != cond_pol_i)
      |=> (upc_o == $past(upc_o) + AW'(1)));
endmodule

// File: tb/useq_sequencer_bench.sv
`timescale 1ns/1ps
module useq_sequencer_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       hold_i;
  logic [1:0] src_i;
  logic       page_i;
  logic [7:0] const_i;
  logic [7:0] cond_i;
  logic [2:0] cond_sel_i;
  logic       cond_pol_i;
  logic       stk_en_i;
  logic       stk_push_i;
  logic [8:0] upc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [8:0] exp_q [$];
  string      tag_q [$];

  // reference model state
  logic [8:0] m_pc;
  logic [8:0] m_s [4];
  int         m_cnt;

  always #10 clk = ~clk;

  useq_sequencer u_useq_sequencer (
    .clk(clk), .rst(rst), .hold_i(hold_i), .src_i(src_i), .page_i(page_i),
    .const_i(const_i), .cond_i(cond_i), .cond_sel_i(cond_sel_i),
    .cond_pol_i(cond_pol_i), .stk_en_i(stk_en_i), .stk_push_i(stk_push_i),
    .upc_o(upc_o)
  );

  // monitor: compares each registered address shortly after its edge
  logic [8:0] mon_e;
  string      mon_t;
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      mon_e = exp_q.pop_front();
      mon_t = tag_q.pop_front();
      checks++;
      if (upc_o !== mon_e) begin
        errors++;
        $display("FAIL %s: upc actual=%h expected=%h", mon_t, upc_o, mon_e);
      end
    end
  end

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1; hold_i = 1'b0; stk_en_i = 1'b0; src_i = 2'd0;
    m_pc = '0; m_cnt = 0;
    for (int i = 0; i < 4; i++) m_s[i] = '0;
    exp_q.push_back(m_pc); tag_q.push_back(tag);
  endtask

  task automatic step(input logic [1:0] src, input logic pg, input logic [7:0] k,
                      input logic [2:0] sel, input logic pol, input logic en,
                      input logic psh, input logic hld, input string tag);
    logic [8:0] inc, nx;
    @(negedge clk);
    rst = 1'b0; src_i = src; page_i = pg; const_i = k; cond_sel_i = sel;
    cond_pol_i = pol; stk_en_i = en; stk_push_i = psh; hold_i = hld;
    inc = m_pc + 9'd1;
    case (src)
      2'd0: nx = inc;
      2'd1: nx = m_s[0];
      2'd2: nx = {pg, k};
      default: nx = (cond_i[sel] == pol) ? {pg, k} : inc;
    endcase
    if (!hld) begin
      if (en) begin
        if (psh) begin
          for (int i = 3; i > 0; i--) m_s[i] = m_s[i-1];
          m_s[0] = inc;
          if (m_cnt < 4) m_cnt++;
        end else begin
          if (m_cnt > 1) for (int i = 0; i < 3; i++) m_s[i] = m_s[i+1];
          if (m_cnt > 0) m_cnt--;
        end
      end
      m_pc = nx;
    end
    exp_q.push_back(m_pc); tag_q.push_back(tag);
  endtask

  task automatic seq(input string t);               step(2'd0,0,8'h00,0,0,0,0,0,t); endtask
  task automatic jmp(input logic p, input logic [7:0] k, input string t);
                                                     step(2'd2,p,k,0,0,0,0,0,t); endtask
  task automatic call(input logic p, input logic [7:0] k, input string t);
                                                     step(2'd2,p,k,0,0,1,1,0,t); endtask
  task automatic ret(input string t);               step(2'd1,0,8'h00,0,0,1,0,0,t); endtask
  task automatic peek(input string t);              step(2'd1,0,8'h00,0,0,0,0,0,t); endtask
  task automatic cj(input logic [7:0] k, input logic [2:0] s, input logic pol, input string t);
                                                     step(2'd3,0,k,s,pol,0,0,0,t); endtask

  initial begin
    rst = 1'b1; hold_i = 1'b0; src_i = '0; page_i = 1'b0; const_i = '0;
    cond_i = 8'b0000_0100; cond_sel_i = '0; cond_pol_i = 1'b0;
    stk_en_i = 1'b0; stk_push_i = 1'b0;
    do_reset("R1"); do_reset("R1");
    seq("R2"); seq("R2"); seq("R2");
    jmp(1'b1, 8'hFF, "R3"); seq("R2 wrap");
    jmp(1'b0, 8'h3C, "R3");
    cj(8'h50, 3'd2, 1'b1, "R4 taken on one");
    cj(8'h60, 3'd2, 1'b0, "R4 not taken");
    cj(8'h70, 3'd3, 1'b0, "R4 taken on zero");
    cj(8'h80, 3'd3, 1'b1, "R4 not taken");
    // call / return
    call(1'b1, 8'h20, "R5 call"); seq("R5"); ret("R5 return after call");
    // stack jump without pointer change
    call(1'b0, 8'h90, "R6 call"); peek("R6 peek"); peek("R6 peek again");
    ret("R6 return"); ret("R9 empty pop");
    // push bit ignored without enable
    call(1'b0, 8'hA0, "R11 call");
    step(2'd0,0,8'h00,0,0,0,1,0,"R11 push bit only");
    ret("R11 return"); ret("R9 empty pop repeats");
    // four-level nesting
    call(1'b0, 8'h10, "R7"); call(1'b0, 8'h20, "R7");
    call(1'b0, 8'h30, "R7"); call(1'b0, 8'h40, "R7");
    ret("R7"); ret("R7"); ret("R7"); ret("R7"); ret("R9");
    // overflow: five pushes
    call(1'b1, 8'h01, "R8"); call(1'b1, 8'h02, "R8"); call(1'b1, 8'h03, "R8");
    call(1'b1, 8'h04, "R8"); call(1'b1, 8'h05, "R8");
    ret("R8"); ret("R8"); ret("R8"); ret("R8 oldest dropped"); ret("R9 after overflow");
    // hold freezes address and stack
    call(1'b0, 8'hC0, "R10 call");
    step(2'd2,1,8'h77,0,0,1,1,1,"R10 held jump+push");
    step(2'd1,0,8'h00,0,0,1,0,1,"R10 held pop");
    seq("R10"); ret("R10 stack intact");
    // reset mid-run empties the stack
    call(1'b1, 8'hEE, "R1 before reset");
    do_reset("R1 mid-run");
    ret("R1 empty after reset");
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule